// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Engine

This block computes the CRC-32 frame check sequence used by Ethernet over a stream of bytes. Each accepted byte is folded into a 32-bit shift register, least significant bit first. A start strobe opens a frame and presets the register to all ones. An end strobe closes the frame.

One cycle after the closing byte, the block pulses `done`. With that pulse it presents two results. The first is the sequence to transmit, already in wire byte order. The second is a flag that says whether the register settled on the good-frame residue. A transmitter sends the payload through the block and appends `fcsOut`. A receiver sends the whole frame, including the received check sequence, through the block and reads `frameGood`.

Top module: `eth_fcs_engine`

## Requirements
- R1: While `rstN` is low, and on the first rising edge after it goes high, `done`, `frameGood` and `fcsOut` are all zero.
- R2: The register uses the reflected polynomial 0xEDB88320. Each byte is applied bit 0 first. For the ASCII bytes "123456789", `fcsOut` is 0x2639F4CB.
- R3: A byte accepted with `inSof` high is folded into a register freshly preset to 0xFFFFFFFF. This holds even when the previous frame was never closed, so an unclosed frame leaves no trace in the next result.
- R4: `fcsOut` holds the complemented register with its four bytes swapped. `fcsOut[31:24]` is the first byte to send, and each byte goes out bit 0 first. The value equals the usual CRC-32 result C written as {C[7:0], C[15:8], C[23:16], C[31:24]}.
- R5: `done` is high for exactly one cycle. That cycle follows the rising edge that accepted a byte with both `inValid` and `inEof` high, within an open frame or together with `inSof`.
- R6: `frameGood` is 1 exactly when the 32-bit bit-reversal of the register, after it has absorbed the whole frame including its check sequence, equals 0xC704DD7B. A frame with any bit flipped gives 0.
- R7: `fcsOut` and `frameGood` change only when `done` is high. Idle cycles with `inValid` low have no effect.
- R8: A one-byte frame, with `inSof` and `inEof` high in the same valid cycle, gives the CRC of that single byte.
- R9: Valid bytes that arrive while no frame is open and `inSof` is low are ignored. An `inEof` on such a byte produces no `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Byte on `inData` is present this cycle |
| inSof | input | 1 | Byte is the first of a frame |
| inEof | input | 1 | Byte is the last of a frame |
| inData | input | 8 | Frame byte |
| done | output | 1 | One-cycle pulse after a frame closes |
| fcsOut | output | 32 | Check sequence in wire byte order |
| frameGood | output | 1 | Residue matched for the closed frame |

## Verification
The bench uses four groups of frames.

- The known nine-character string fixes the polynomial, the bit order and the output byte order together.
- Random payloads of 64 to 1518 bytes are compared against a bitwise model. Each is then resent with its own check sequence appended, which must raise `frameGood`. This separates a wrong preset or complement from a wrong residue compare.
- Copies of those frames with one bit flipped must clear the flag.
- Short cases cover the edges of frame control. A one-byte frame, back-to-back frames with no idle cycle, and a frame abandoned by a fresh start separate the preset-on-start rule from the close handling. Stray bytes outside a frame must neither disturb the results nor pulse `done`.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int CRC_W = 32;
  localparam int BYTE_W = 8;
  localparam int NUM_BYTES = CRC_W / BYTE_W;
  localparam logic [CRC_W-1:0] POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] PRESET = '1;
  localparam logic [CRC_W-1:0] RESIDUE = 32'hC704DD7B;

  typedef struct packed {
    logic preset;  // start register from all ones
    logic absorb;  // fold the input byte
    logic finish;  // latch results this cycle
  } fcsStrobes_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] cur,
                                               input logic [BYTE_W-1:0] din);
    logic [CRC_W-1:0] r;
    r = cur;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ din[i]) r = (r >> 1) ^ POLY_REFL;
      else               r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                inSof,
  input  logic                inEof,
  output fcs_pkg::fcsStrobes_t strobes,
  output logic                done
);
  logic inFrame;
  logic accept;

  // A byte counts when it opens a frame or arrives inside one (R9).
  assign accept = inValid && (inSof || inFrame);

  always_comb begin
    strobes.preset = inValid && inSof;
    strobes.absorb = accept;
    strobes.finish = accept && inEof;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= strobes.finish;
      if (accept) inFrame <= !inEof;
    end
  end
endmodule

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int CRC_BITS = CRC_W,
  parameter int LANE_BITS = BYTE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fcsStrobes_t          strobes,
  input  logic [LANE_BITS-1:0] inData,
  output logic [CRC_BITS-1:0]  fcsOut,
  output logic                 frameGood
);
  localparam int LANES = CRC_BITS / LANE_BITS;

  logic [CRC_BITS-1:0] crcReg;
  logic [CRC_BITS-1:0] stepBase;
  logic [CRC_BITS-1:0] crcNext;
  logic [CRC_BITS-1:0] crcInv;
  logic [CRC_BITS-1:0] wireOrder;
  logic [CRC_BITS-1:0] crcRev;

  assign stepBase = strobes.preset ? PRESET : crcReg;
  assign crcNext  = crcStep(stepBase, inData);
  assign crcInv   = ~crcNext;

  // Byte swap: lowest byte of the complement leaves first.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wireOrder[CRC_BITS-1-g*LANE_BITS -: LANE_BITS] =
      crcInv[g*LANE_BITS +: LANE_BITS];
  end

  // Full 32-bit reversal for the residue compare.
  for (genvar b = 0; b < CRC_BITS; b++) begin : g_rev
    assign crcRev[b] = crcNext[CRC_BITS-1-b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg    <= PRESET;
      fcsOut    <= '0;
      frameGood <= 1'b0;
    end else begin
      if (strobes.absorb) crcReg <= crcNext;
      if (strobes.finish) begin
        fcsOut    <= wireOrder;
        frameGood <= (crcRev == RESIDUE);
      end
    end
  end
endmodule

// File: rtl/eth_fcs_engine.sv
module eth_fcs_engine (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSof,
  input  logic        inEof,
  input  logic [7:0]  inData,
  output logic        done,
  output logic [31:0] fcsOut,
  output logic        frameGood
);
  fcs_pkg::fcsStrobes_t strobes;

  fcs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof),
    .inEof(inEof), .strobes(strobes), .done(done)
  );

  fcs_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inData(inData),
    .fcsOut(fcsOut), .frameGood(frameGood)
  );
endmodule

// File: rtl/eth_fcs_checker.sv
module eth_fcs_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inSof,
  input logic        inEof,
  input logic        done,
  input logic [31:0] fcsOut,
  input logic        frameGood
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!done && !frameGood && fcsOut == 32'h0));

  p_open_close_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof && inEof) |=> done);

  p_done_has_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(inValid && inEof));

  p_results_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(fcsOut) && $stable(frameGood)));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !$past(inValid && inEof && inSof)) |=> !done || $past(inValid && inEof));
endmodule

bind eth_fcs_engine eth_fcs_checker chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
  .done(done), .fcsOut(fcsOut), .frameGood(frameGood)
);

// File: tb/eth_fcs_engine_tb_top.sv
module eth_fcs_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN = 1530;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0] inData = 8'h0;
  logic done, frameGood;
  logic [31:0] fcsOut;

  int testCount = 0;
  int failCount = 0;
  logic [7:0] frame [MAX_LEN];

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_fcs_engine dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inData(inData), .done(done), .fcsOut(fcsOut), .frameGood(frameGood)
  );

  function automatic logic [31:0] modelCrc(input int len);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++)
      for (int k = 0; k < 8; k++)
        r = (r[0] ^ frame[i][k]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return ~r;
  endfunction

  function automatic logic [31:0] wireOf(input logic [31:0] c);
    return {c[7:0], c[15:8], c[23:16], c[31:24]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    end
  endtask

  // Drive frame[0..len-1]; optionally leave the frame unclosed.
  task automatic sendFrame(input int len, input bit close);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSof = (i == 0); inEof = close && (i == len - 1);
      inData = frame[i];
    end
  endtask

  // After sendFrame with close: one negedge later done must be high.
  task automatic expectResult(input string req, input logic [31:0] expFcs,
                              input logic expGood, input bit checkFcs);
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    check({req, " done"}, {31'h0, done}, 32'h1);
    if (checkFcs) check({req, " fcs"}, fcsOut, expFcs);
    check({req, " good"}, {31'h0, frameGood}, {31'h0, expGood});
    @(negedge clk);
    check("R5 done single cycle", {31'h0, done}, 32'h0);
  endtask

  task automatic fcsAndResidue(input int len, input string tag);
    logic [31:0] c;
    c = modelCrc(len);
    sendFrame(len, 1'b1);
    expectResult({tag, " R4"}, wireOf(c), 1'b0, 1'b1);
    frame[len] = c[7:0]; frame[len+1] = c[15:8];
    frame[len+2] = c[23:16]; frame[len+3] = c[31:24];
    sendFrame(len + 4, 1'b1);
    expectResult({tag, " R6 good"}, 32'h0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] c, savedFcs;
    int len;
    void'($urandom(32'h1F2E3D4C));
    #(1);
    // R1: reset state
    check("R1 done", {31'h0, done}, 32'h0);
    check("R1 fcs", fcsOut, 32'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 good", {31'h0, frameGood}, 32'h0);
    check("R1 fcs after release", fcsOut, 32'h0);

    // R2: check string "123456789"
    for (int i = 0; i < 9; i++) frame[i] = 8'h31 + 8'(i);
    sendFrame(9, 1'b1);
    expectResult("R2 check string", 32'h2639F4CB, 1'b0, 1'b1);

    // R8: one-byte frame
    frame[0] = 8'hA5;
    c = modelCrc(1);
    sendFrame(1, 1'b1);
    expectResult("R8 single byte", wireOf(c), 1'b0, 1'b1);

    // R7: idle cycles and values held
    savedFcs = fcsOut;
    idle(5);
    check("R7 hold fcs", fcsOut, savedFcs);
    check("R7 no done", {31'h0, done}, 32'h0);

    // R9: stray bytes outside a frame, one with eof
    @(negedge clk); inValid = 1'b1; inSof = 1'b0; inEof = 1'b0; inData = 8'h77;
    @(negedge clk); inEof = 1'b1; inData = 8'h12;
    @(negedge clk); inValid = 1'b0; inEof = 1'b0;
    check("R9 stray no done", {31'h0, done}, 32'h0);
    check("R9 stray fcs held", fcsOut, savedFcs);
    @(negedge clk);
    check("R9 stray no done later", {31'h0, done}, 32'h0);

    // R3: abandoned frame then restart
    for (int i = 0; i < 20; i++) frame[i] = 8'($urandom);
    sendFrame(20, 1'b0);
    for (int i = 0; i < 70; i++) frame[i] = 8'($urandom);
    c = modelCrc(70);
    sendFrame(70, 1'b1);
    expectResult("R3 restart", wireOf(c), 1'b0, 1'b1);

    // R5/R3: back-to-back frames, no idle
    for (int i = 0; i < 64; i++) frame[i] = 8'($urandom);
    sendFrame(64, 1'b1);
    c = modelCrc(64);
    sendFrame(64, 1'b1);
    expectResult("R5 back to back", wireOf(c), 1'b0, 1'b1);

    // R4/R6: random frames, then corrupted copies
    for (int f = 0; f < 12; f++) begin
      len = 64 + int'($urandom % 1455);
      for (int i = 0; i < len; i++) frame[i] = 8'($urandom);
      fcsAndResidue(len, "random");
      idle(int'($urandom % 4));
      begin
        int pos = int'($urandom % (len + 4));
        frame[pos] = frame[pos] ^ (8'h1 << ($urandom % 8));
        sendFrame(len + 4, 1'b1);
        expectResult("R6 corrupted", 32'h0, 1'b0, 1'b0);
      end
    end

    // R6: minimum frame of zeros
    for (int i = 0; i < 60; i++) frame[i] = 8'h00;
    fcsAndResidue(60, "zeros");

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule